// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block sequences power-down for a small processor core. When the core retires a sleep instruction, the controller first checks whether any interrupt source is already pending. If one is, the sleep turns into a no-op and the core keeps running. If none is, the controller gates the core clock, freezes the program counter and pulses a clear to the watchdog. It also records the outcome in two status bits. Software reads the power-down bit afterwards to learn which outcome occurred.

A wake source is any interrupt line whose flag and enable are both high. The global interrupt enable plays no part in waking. On wake-up, a crystal oscillator mode first waits out a start-up delay, while a direct clock mode resumes at once. If the global enable was set at the moment of waking, the core executes one more in-line instruction and then two dummy cycles, and jumps to the interrupt vector. If the global enable was clear, the core simply carries on in-line. Each clock cycle of the block is one instruction cycle.

Top module: `slpw_ctrl`

## Requirements
- R1: While reset is active, and in the cycle after its release, `to_o` and `pd_o` are 1, `sleeping_o` is 0, `core_clk_en_o` is 1 and `pc_o` is 0.
- R2: A wake condition exists when some bit index has both `irq_flag_i` and `irq_en_i` high, whatever `gie_i` is. A sleeping core leaves sleep on the edge that sees it. A flag and an enable at different indexes do not wake it.
- R3: A sleep strobe whose previous cycle already held a wake condition is a no-op. `pd_o` and `to_o` keep their values, `wdt_clr_o` stays 0, `sleeping_o` stays 0 and `pc_o` keeps advancing by one per cycle.
- R4: A sleep strobe with no wake condition in the previous cycle completes. From the next cycle on, `pd_o`=0, `to_o`=1 and `sleeping_o`=1, and `core_clk_en_o`=0. `wdt_clr_o` is 1 for exactly that one cycle. `pc_o` holds at the strobe address plus one for as long as the core sleeps.
- R5: A wake condition that first appears in the same cycle as the sleep strobe still lets the sleep complete. The core then wakes on the following edge.
- R6: With `osc_mode_i` at 0, 1 or 2 (crystal modes), `sleeping_o` stays 1 for exactly STARTUP_CYC cycles after the waking edge. With `osc_mode_i`=3 it drops on the waking edge.
- R7: If `gie_i` was 1 at the waking edge, the resume runs in order: one cycle in which `pc_o` advances, then two dummy cycles with `pc_o` held and `core_clk_en_o`=1. `irq_vec_o`=1 only in the second dummy cycle, and `pc_o` then becomes VEC_ADDR.
- R8: If `gie_i` was 0 at the waking edge, `irq_vec_o` stays 0 and `pc_o` resumes counting up from the held value.
- R9: A sleep strobe that arrives while the core is not in normal running state (such as during the dummy cycles) is ignored. No watchdog pulse is issued and `sleeping_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_exec_i | input | 1 | Sleep instruction executes this cycle |
| irq_flag_i | input | NUM_SRC | Interrupt flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| osc_mode_i | input | 2 | 0..2 crystal modes, 3 direct clock |
| sleeping_o | output | 1 | Core is powered down or waiting on start-up |
| core_clk_en_o | output | 1 | Core clock enable |
| wdt_clr_o | output | 1 | One-cycle watchdog and prescaler clear |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |
| irq_vec_o | output | 1 | Vector fetch request |
| pc_o | output | PC_W | Program counter |

## Verification
The sleep strobe and the rise of a wake condition can land in the same instruction cycle, and the outcome depends on which one the controller treats as first. The bench provokes this in three ways. It raises a matching flag one cycle before the strobe, which must give a no-op with PD still set and no watchdog pulse. It raises the flag together with the strobe, which must give a completed sleep with PD cleared and the watchdog pulsed, followed by a wake one edge later. It raises the flag only after the core sleeps. In each case the verdict comes from PD, the watchdog pulse, the sleeping indicator and the program counter, all read at the ports.

// File: rtl/slpw_pkg.sv
`timescale 1ns/1ps
package slpw_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_SLEEP  = 2'd1,
      ST_START  = 2'd2,
      ST_RESUME = 2'd3
   } slpw_state_e;

   localparam logic [1:0] OSC_DIRECT = 2'd3;

   function automatic logic needs_startup(input logic [1:0] mode);
      return mode != OSC_DIRECT;
   endfunction
endpackage

// File: rtl/slpw_wake_detect.sv
`timescale 1ns/1ps
module slpw_wake_detect #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] flag_i,
   input  logic [NUM_SRC-1:0] en_i,
   output logic               wake_now_o,
   output logic               wake_prev_o
);
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = flag_i[i] & en_i[i];
   end

   assign wake_now_o = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_prev_o <= 1'b0;
      else        wake_prev_o <= wake_now_o;
   end
endmodule

// File: rtl/slpw_startup_timer.sv
`timescale 1ns/1ps
module slpw_startup_timer #(
   parameter int STARTUP_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);

   if (STARTUP_CYC < 1) begin : g_bad
      $error("STARTUP_CYC must be at least 1");
   end

   if (STARTUP_CYC > 1) begin : g_cnt
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt <= '0;
         else if (!run_i)  cnt <= '0;
         else if (cnt != LAST) cnt <= cnt + 1'b1;
      end
      assign done_o = run_i && (cnt == LAST);

      assert_cnt_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !run_i |=> (cnt == '0));
   end else begin : g_nocnt
      assign done_o = run_i;
   end
endmodule

// File: rtl/slpw_ctrl.sv
`timescale 1ns/1ps
module slpw_ctrl
   import slpw_pkg::*;
#(
   parameter int NUM_SRC     = 8,
   parameter int PC_W        = 13,
   parameter int VEC_ADDR    = 4,
   parameter int STARTUP_CYC = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_exec_i,
   input  logic [NUM_SRC-1:0] irq_flag_i,
   input  logic [NUM_SRC-1:0] irq_en_i,
   input  logic               gie_i,
   input  logic [1:0]         osc_mode_i,
   output logic               sleeping_o,
   output logic               core_clk_en_o,
   output logic               wdt_clr_o,
   output logic               to_o,
   output logic               pd_o,
   output logic               irq_vec_o,
   output logic [PC_W-1:0]    pc_o
);
   localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);
   localparam logic [1:0]      LAST_PH = 2'd2;

   if (NUM_SRC < 1) begin : g_chk_src
      $error("NUM_SRC must be at least 1");
   end
   if (PC_W < 4 || VEC_ADDR >= (1 << PC_W)) begin : g_chk_pc
      $error("PC_W too small for VEC_ADDR");
   end

   slpw_state_e state, nxt;
   logic        wake_now, wake_prev;
   logic        st_done;
   logic        gie_q;
   logic [1:0]  ph;
   logic        sleep_ok;

   slpw_wake_detect #(.NUM_SRC(NUM_SRC)) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag_i     (irq_flag_i),
      .en_i       (irq_en_i),
      .wake_now_o (wake_now),
      .wake_prev_o(wake_prev)
   );

   slpw_startup_timer #(.STARTUP_CYC(STARTUP_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (state == ST_START),
      .done_o(st_done)
   );

   assign sleep_ok = (state == ST_RUN) && sleep_exec_i && !wake_prev;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN:    if (sleep_ok) nxt = ST_SLEEP;
         ST_SLEEP:  if (wake_now)
                       nxt = needs_startup(osc_mode_i) ? ST_START
                           : (gie_i ? ST_RESUME : ST_RUN);
         ST_START:  if (st_done) nxt = gie_q ? ST_RESUME : ST_RUN;
         ST_RESUME: if (ph == LAST_PH) nxt = ST_RUN;
         default:   nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         gie_q     <= 1'b0;
         ph        <= '0;
         pc_o      <= '0;
         to_o      <= 1'b1;
         pd_o      <= 1'b1;
         wdt_clr_o <= 1'b0;
      end else begin
         state     <= nxt;
         wdt_clr_o <= sleep_ok;
         if (sleep_ok) begin
            to_o <= 1'b1;
            pd_o <= 1'b0;
         end
         if (state == ST_SLEEP && wake_now) gie_q <= gie_i;
         ph <= (state == ST_RESUME) ? ph + 1'b1 : 2'd0;
         unique case (state)
            ST_RUN:    pc_o <= pc_o + 1'b1;
            ST_RESUME: if (ph == 2'd0)         pc_o <= pc_o + 1'b1;
                       else if (ph == LAST_PH) pc_o <= VEC;
            default:   pc_o <= pc_o;
         endcase
      end
   end

   assign sleeping_o    = (state == ST_SLEEP) || (state == ST_START);
   assign core_clk_en_o = !sleeping_o;
   assign irq_vec_o     = (state == ST_RESUME) && (ph == LAST_PH);

   assert_wdt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr_o |=> !wdt_clr_o);
   assert_pd_in_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sleeping_o |-> !pd_o);
   assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sleeping_o |=> $stable(pc_o));
   assert_nop_keeps_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_exec_i && wake_prev) |=> (pd_o == $past(pd_o) && !wdt_clr_o && !sleeping_o));
   assert_vector_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vec_o |=> (pc_o == VEC));
   assert_ignore_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RUN && sleep_exec_i) |=> !wdt_clr_o);
endmodule

// File: tb/slpw_ctrl_tb.sv
`timescale 1ns/1ps
module slpw_ctrl_tb;
   localparam int NS = 8;
   localparam int PW = 13;
   localparam int VEC = 4;
   localparam int SUC = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_exec = 1'b0;
   logic [NS-1:0] flg = '0, en = '0;
   logic gie = 1'b0;
   logic [1:0] osc = 2'd3;
   logic sleeping, clk_en, wdt_clr, to_b, pd_b, irq_vec;
   logic [PW-1:0] pc;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   slpw_ctrl #(.NUM_SRC(NS), .PC_W(PW), .VEC_ADDR(VEC), .STARTUP_CYC(SUC)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_exec_i(sleep_exec), .irq_flag_i(flg),
      .irq_en_i(en), .gie_i(gie), .osc_mode_i(osc), .sleeping_o(sleeping),
      .core_clk_en_o(clk_en), .wdt_clr_o(wdt_clr), .to_o(to_b), .pd_o(pd_b),
      .irq_vec_o(irq_vec), .pc_o(pc));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic quiet();
      flg = '0; en = '0; sleep_exec = 0;
      tick(); tick();
   endtask

   task automatic t_reset();
      tick(); tick();
      chk("R1 to", to_b, 1); chk("R1 pd", pd_b, 1);
      rst_n = 1'b1;
      chk("R1 sleeping", sleeping, 0); chk("R1 clk_en", clk_en, 1);
      chk("R1 pc", int'(pc), 0);
   endtask

   task automatic t_nop_R3();
      int p0;
      flg[2] = 1; en[2] = 1;
      tick();
      p0 = int'(pc); sleep_exec = 1;
      tick();
      chk("R3 sleeping", sleeping, 0); chk("R3 pd", pd_b, 1);
      chk("R3 to", to_b, 1); chk("R3 wdt", wdt_clr, 0);
      chk("R3 pc", int'(pc), p0 + 1);
      quiet();
   endtask

   task automatic t_sleep_inline();
      int p0;
      osc = 2'd3; gie = 0;
      p0 = int'(pc); sleep_exec = 1;
      tick();
      sleep_exec = 0;
      chk("R4 sleeping", sleeping, 1); chk("R4 clk_en", clk_en, 0);
      chk("R4 pd", pd_b, 0); chk("R4 to", to_b, 1);
      chk("R4 wdt", wdt_clr, 1); chk("R4 pc", int'(pc), p0 + 1);
      flg[4] = 1; en[3] = 1;
      tick();
      chk("R4 wdt single", wdt_clr, 0);
      chk("R2 mismatched no wake", sleeping, 1);
      chk("R4 pc held", int'(pc), p0 + 1);
      flg = '0; en = '0; flg[7] = 1; en[7] = 1;
      tick();
      chk("R2 wake with gie low", sleeping, 0);
      chk("R8 no vector", irq_vec, 0);
      chk("R8 pc", int'(pc), p0 + 1);
      flg = '0; en = '0;
      tick();
      chk("R8 pc resumes", int'(pc), p0 + 2);
      chk("R8 no vector later", irq_vec, 0);
      quiet();
   endtask

   task automatic t_sleep_vector();
      int p0;
      osc = 2'd3; gie = 1;
      p0 = int'(pc); sleep_exec = 1;
      tick(); sleep_exec = 0;
      tick();
      flg[0] = 1; en[0] = 1;
      tick();
      flg = '0; en = '0;
      chk("R7 awake", clk_en, 1); chk("R7 ph0 pc", int'(pc), p0 + 1);
      chk("R7 ph0 vec", irq_vec, 0);
      tick();
      chk("R7 ph1 pc", int'(pc), p0 + 2); chk("R7 ph1 vec", irq_vec, 0);
      sleep_exec = 1;
      tick();
      sleep_exec = 0;
      chk("R7 ph2 pc", int'(pc), p0 + 2); chk("R7 ph2 vec", irq_vec, 1);
      chk("R9 no wdt", wdt_clr, 0); chk("R9 not sleeping", sleeping, 0);
      tick();
      chk("R7 vector pc", int'(pc), VEC); chk("R7 vec done", irq_vec, 0);
      tick();
      chk("R7 after vector", int'(pc), VEC + 1);
      chk("R9 still awake", sleeping, 0);
      gie = 0;
      quiet();
   endtask

   task automatic t_same_cycle_R5();
      osc = 2'd3;
      sleep_exec = 1; flg[1] = 1; en[1] = 1;
      tick();
      sleep_exec = 0;
      chk("R5 sleeps", sleeping, 1); chk("R5 wdt", wdt_clr, 1);
      chk("R5 pd", pd_b, 0);
      tick();
      chk("R5 wakes next edge", sleeping, 0);
      quiet();
   endtask

   task automatic t_crystal_R6();
      for (int m = 0; m < 3; m++) begin
         int p0, n;
         osc = 2'(m);
         p0 = int'(pc); sleep_exec = 1;
         tick(); sleep_exec = 0;
         tick();
         flg[5] = 1; en[5] = 1;
         tick();
         flg = '0; en = '0;
         n = 0;
         while (sleeping && n < 5000) begin
            n++;
            if (n == 1) chk("R6 pc frozen", int'(pc), p0 + 1);
            tick();
         end
         chk($sformatf("R6 startup mode %0d", m), n, SUC);
         tick();
         chk("R6 pc after start", int'(pc), p0 + 2);
         quiet();
      end
      osc = 2'd3;
   endtask

   initial begin
      t_reset();
      t_nop_R3();
      t_sleep_inline();
      t_sleep_vector();
      t_same_cycle_R5();
      t_crystal_R6();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule